// File: doc/BRIEF.md
# Clock Ratio Transition Sequencer

This block moves a processor clock from its present divide ratio to a new one. The ratios it supports are 1, 2, 4, 6 and 8. A caller presents a ratio index together with a one-cycle start pulse. The block reads the present control word, whose low three bits hold the divider code. It then runs the move as an ordered list of requests on three request/acknowledge channels:

- a divider write channel, which writes the new control word;
- a refresh channel, which asks the memory controller to recompute its refresh count for a given ratio;
- a self-refresh channel, which turns memory self-refresh on or off.

The order of the requests depends on the direction of the move and on the two ratios involved. A jump between divide-by-1 and any ratio above 2 always passes through divide-by-2 as an intermediate leg. After each divider write is acknowledged, the block holds off for a fixed number of cycles so the clock generator can lock. Only then does it issue the next request.

The PLL, the memory controller and the refresh arithmetic sit outside the block. They answer the requests. When the sequence ends, the block pulses done. Busy is high from the cycle after the accepted start through the done cycle.

Top module: `clkdiv_transition_seq`

## Requirements
- R1: Ratio index 0, 1, 2, 3, 4 selects ratio 1, 2, 4, 6, 8. The divider codes in the low three bits of the written word are 3'b000, 3'b001, 3'b011, 3'b010 and 3'b100 for those ratios. Every other code is illegal.
- R2: A divider write replaces only bits [2:0] of the control word captured at start. All higher bits are written back unchanged.
- R3: Going from ratio 1 to ratio 2, the order is: a refresh request for ratio 2 with drain set, then the divider write, then a self-refresh request with enable set.
- R4: Going from ratio 2 to ratio 1, the order is: a self-refresh request with enable clear, then the divider write, then a refresh request for ratio 1 with drain clear.
- R5: Any other move to a larger ratio issues a refresh request for the new ratio with drain clear, then the divider write.
- R6: Any other move to a smaller ratio issues the divider write, then a refresh request for the new ratio with drain set.
- R7: A move from ratio 1 to ratio 4, 6 or 8 runs as a 1-to-2 leg followed by a 2-to-target leg. A move from ratio 4, 6 or 8 to ratio 1 runs as a leg to 2 followed by a 2-to-1 leg. Each leg follows R3 to R6.
- R8: After a divider write is acknowledged, no request of any kind is raised for at least LOCK_CYCLES (default 16) cycles.
- R9: When the target ratio equals the present ratio, no request is raised and done pulses in the cycle after start.
- R10: An index above 4, or an illegal present code, raises no request. In that case the block sets an error flag and pulses done in the cycle after start. The flag stays set until reset.
- R11: A start pulse arriving while busy is high is ignored. Busy stays high until done has pulsed, then falls. Done lasts one cycle.
- R12: At most one request line is high in any cycle. Each request is held until its acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start of a ratio change |
| target_idx_i | input | 3 | Target ratio index, 0..4 legal |
| cur_ctrl_i | input | CTRL_W | Present control word, divider code in [2:0] |
| div_wr_req_o | output | 1 | Divider write request |
| div_wr_data_o | output | CTRL_W | Control word to write |
| div_wr_ack_i | input | 1 | Divider write acknowledge |
| refr_req_o | output | 1 | Refresh count update request |
| refr_ratio_o | output | 4 | New ratio for the refresh update (1, 2, 4, 6, 8) |
| refr_drain_o | output | 1 | Update must wait for old and new counts to drain |
| refr_ack_i | input | 1 | Refresh update acknowledge |
| sref_req_o | output | 1 | Self-refresh control request |
| sref_en_o | output | 1 | 1 turns self-refresh on, 0 turns it off |
| sref_ack_i | input | 1 | Self-refresh acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Sticky illegal index or code flag |

## Verification
A wrong step pointer or leg register in this block shows up as a request on the wrong channel, or as a wrong ratio, drain or data value. Either appears at the very next request, so the ordered scoreboard reports it within one handshake of the fault. A lock timer that expires early shows up as a request raised fewer than LOCK_CYCLES cycles after a divider acknowledge. A corrupted leg or state register shows up in one of three ways at the ports: a missing or extra request, done arriving too early or never, or a final control word that differs from the expected one.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int IDX_W      = 3;
    localparam int CODE_W     = 3;
    localparam int RATIO_W    = 4;
    localparam int NUM_RATIOS = 5;

    typedef enum logic [2:0] {
        K_NONE,
        K_REFR_KEEP,
        K_REFR_DRAIN,
        K_DIV,
        K_SREF_OFF,
        K_SREF_ON
    } step_e;

    typedef struct packed {
        step_e      s0;
        step_e      s1;
        step_e      s2;
        logic [1:0] n;
    } leg_plan_t;

    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_LOCK,
        F_DONE
    } fsm_e;

    function automatic logic [CODE_W-1:0] idx_to_code(input logic [IDX_W-1:0] idx);
        logic [CODE_W-1:0] c;
        case (idx)
            3'd0:    c = 3'b000;
            3'd1:    c = 3'b001;
            3'd2:    c = 3'b011;
            3'd3:    c = 3'b010;
            default: c = 3'b100;
        endcase
        return c;
    endfunction

    function automatic logic [RATIO_W-1:0] idx_to_ratio(input logic [IDX_W-1:0] idx);
        logic [RATIO_W-1:0] r;
        case (idx)
            3'd0:    r = 4'd1;
            3'd1:    r = 4'd2;
            3'd2:    r = 4'd4;
            3'd3:    r = 4'd6;
            default: r = 4'd8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cdt_code_decode.sv
module cdt_code_decode
    import cdt_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              valid_o
);

    always_comb begin
        valid_o = 1'b1;
        case (code_i)
            3'b000:  idx_o = 3'd0;
            3'b001:  idx_o = 3'd1;
            3'b011:  idx_o = 3'd2;
            3'b010:  idx_o = 3'd3;
            3'b100:  idx_o = 3'd4;
            default: begin
                idx_o   = 3'd0;
                valid_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cdt_step_planner.sv
module cdt_step_planner
    import cdt_pkg::*;
(
    input  logic [IDX_W-1:0] from_i,
    input  logic [IDX_W-1:0] to_i,
    output leg_plan_t        plan_o
);

    // One leg never crosses between ratio 1 and a ratio above 2; the
    // caller splits such moves before they reach this table.
    always_comb begin
        if (from_i == 3'd1 && to_i == 3'd0) begin
            plan_o = '{s0: K_SREF_OFF, s1: K_DIV, s2: K_REFR_KEEP, n: 2'd3};
        end else if (from_i == 3'd0 && to_i == 3'd1) begin
            plan_o = '{s0: K_REFR_DRAIN, s1: K_DIV, s2: K_SREF_ON, n: 2'd3};
        end else if (from_i < to_i) begin
            plan_o = '{s0: K_REFR_KEEP, s1: K_DIV, s2: K_NONE, n: 2'd2};
        end else begin
            plan_o = '{s0: K_DIV, s1: K_REFR_DRAIN, s2: K_NONE, n: 2'd2};
        end
    end

endmodule

// File: rtl/cdt_lock_timer.sv
module cdt_lock_timer #(
    parameter int LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);

    localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(LOCK_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/clkdiv_transition_seq.sv
module clkdiv_transition_seq
    import cdt_pkg::*;
#(
    parameter int CTRL_W      = 8,
    parameter int LOCK_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [IDX_W-1:0]    target_idx_i,
    input  logic [CTRL_W-1:0]   cur_ctrl_i,
    output logic                div_wr_req_o,
    output logic [CTRL_W-1:0]   div_wr_data_o,
    input  logic                div_wr_ack_i,
    output logic                refr_req_o,
    output logic [RATIO_W-1:0]  refr_ratio_o,
    output logic                refr_drain_o,
    input  logic                refr_ack_i,
    output logic                sref_req_o,
    output logic                sref_en_o,
    input  logic                sref_ack_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o
);

    localparam int GAP_W = $clog2(LOCK_CYCLES + 1);

    fsm_e              state_q;
    logic [1:0]        step_q;
    logic [IDX_W-1:0]  from_q, to_q, final_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              err_q;

    logic [IDX_W-1:0]  cur_idx;
    logic              cur_ok;
    logic              tgt_ok;
    logic [IDX_W-1:0]  first_to;
    leg_plan_t         plan;
    step_e             kind;
    logic              is_div, is_refr, is_sref;
    logic              in_req, ack_hit, lock_load, lock_done, adv;
    logic              last_step, legs_left;

    cdt_code_decode u_cur_dec (
        .code_i  (cur_ctrl_i[CODE_W-1:0]),
        .idx_o   (cur_idx),
        .valid_o (cur_ok)
    );

    cdt_step_planner u_plan (
        .from_i (from_q),
        .to_i   (to_q),
        .plan_o (plan)
    );

    cdt_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .load_i    (lock_load),
        .expired_o (lock_done)
    );

    assign tgt_ok = (target_idx_i < IDX_W'(NUM_RATIOS));

    // Split moves that cross between ratio 1 and ratios above 2.
    always_comb begin
        if ((cur_idx == 3'd0 && target_idx_i > 3'd1) ||
            (cur_idx > 3'd1 && target_idx_i == 3'd0)) begin
            first_to = 3'd1;
        end else begin
            first_to = target_idx_i;
        end
    end

    always_comb begin
        case (step_q)
            2'd0:    kind = plan.s0;
            2'd1:    kind = plan.s1;
            default: kind = plan.s2;
        endcase
    end

    assign is_div    = (kind == K_DIV);
    assign is_refr   = (kind == K_REFR_KEEP) || (kind == K_REFR_DRAIN);
    assign is_sref   = (kind == K_SREF_OFF) || (kind == K_SREF_ON);
    assign in_req    = (state_q == F_REQ);
    assign ack_hit   = in_req && ((is_div && div_wr_ack_i) ||
                                  (is_refr && refr_ack_i) ||
                                  (is_sref && sref_ack_i));
    assign lock_load = ack_hit && is_div;
    assign adv       = (ack_hit && !is_div) || (state_q == F_LOCK && lock_done);
    assign last_step = ((step_q + 2'd1) == plan.n);
    assign legs_left = (to_q != final_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= F_IDLE;
            step_q  <= '0;
            from_q  <= '0;
            to_q    <= '0;
            final_q <= '0;
            ctrl_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                F_IDLE: begin
                    if (start_i) begin
                        ctrl_q <= cur_ctrl_i;
                        step_q <= '0;
                        if (!tgt_ok || !cur_ok) begin
                            err_q   <= 1'b1;
                            state_q <= F_DONE;
                        end else if (cur_idx == target_idx_i) begin
                            state_q <= F_DONE;
                        end else begin
                            from_q  <= cur_idx;
                            to_q    <= first_to;
                            final_q <= target_idx_i;
                            state_q <= F_REQ;
                        end
                    end
                end
                F_REQ: begin
                    if (lock_load) begin
                        ctrl_q[CODE_W-1:0] <= idx_to_code(to_q);
                        state_q            <= F_LOCK;
                    end
                end
                F_LOCK: ;
                default: state_q <= F_IDLE;
            endcase

            if (adv) begin
                if (!last_step) begin
                    step_q  <= step_q + 2'd1;
                    state_q <= F_REQ;
                end else if (legs_left) begin
                    from_q  <= to_q;
                    to_q    <= final_q;
                    step_q  <= '0;
                    state_q <= F_REQ;
                end else begin
                    state_q <= F_DONE;
                end
            end
        end
    end

    assign div_wr_req_o  = in_req && is_div;
    assign div_wr_data_o = {ctrl_q[CTRL_W-1:CODE_W], idx_to_code(to_q)};
    assign refr_req_o    = in_req && is_refr;
    assign refr_ratio_o  = idx_to_ratio(to_q);
    assign refr_drain_o  = (kind == K_REFR_DRAIN);
    assign sref_req_o    = in_req && is_sref;
    assign sref_en_o     = (kind == K_SREF_ON);
    assign busy_o        = (state_q != F_IDLE);
    assign done_o        = (state_q == F_DONE);
    assign err_o         = err_q;

    // ---------------- assertions ----------------
    logic [IDX_W-1:0] out_idx;
    logic             out_ok;
    logic [GAP_W-1:0] gap_q;

    cdt_code_decode u_out_dec (
        .code_i  (div_wr_data_o[CODE_W-1:0]),
        .idx_o   (out_idx),
        .valid_o (out_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GAP_W'(LOCK_CYCLES);
        end else if (div_wr_req_o && div_wr_ack_i) begin
            gap_q <= '0;
        end else if (gap_q < GAP_W'(LOCK_CYCLES)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r12_one_req: assert property (@(posedge clk) disable iff (rst)
        $onehot0({div_wr_req_o, refr_req_o, sref_req_o}));

    a_r12_hold_req: assert property (@(posedge clk) disable iff (rst)
        (refr_req_o && !refr_ack_i) |=> refr_req_o);

    a_r1_code_legal: assert property (@(posedge clk) disable iff (rst)
        div_wr_req_o |-> (out_ok && out_idx < IDX_W'(NUM_RATIOS)));

    a_r8_lock_gap: assert property (@(posedge clk) disable iff (rst)
        (div_wr_req_o || refr_req_o || sref_req_o) |-> (gap_q == GAP_W'(LOCK_CYCLES)));

    a_r9_equal_done: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && tgt_ok && cur_ok && cur_idx == target_idx_i)
            |=> (done_o && !div_wr_req_o && !refr_req_o && !sref_req_o));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

endmodule

// File: tb/clkdiv_transition_seq_tb_top.sv
`timescale 1ns/1ps
module clkdiv_transition_seq_tb_top;

    localparam int W    = 8;
    localparam int LOCK = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [2:0]   target_idx_i = '0;
    logic [W-1:0] env_ctrl = 8'hA8;
    logic         div_wr_req_o, refr_req_o, refr_drain_o, sref_req_o, sref_en_o;
    logic [W-1:0] div_wr_data_o;
    logic [3:0]   refr_ratio_o;
    logic         div_ack = 1'b0, refr_ack = 1'b0, sref_ack = 1'b0;
    logic         busy_o, done_o, err_o;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    int last_div = -1000;
    bit finished = 0;
    logic [31:0]  exp_q[$];
    logic [W-1:0] exp_ctl;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    clkdiv_transition_seq #(.CTRL_W(W), .LOCK_CYCLES(LOCK)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .target_idx_i(target_idx_i),
        .cur_ctrl_i(env_ctrl),
        .div_wr_req_o(div_wr_req_o), .div_wr_data_o(div_wr_data_o), .div_wr_ack_i(div_ack),
        .refr_req_o(refr_req_o), .refr_ratio_o(refr_ratio_o), .refr_drain_o(refr_drain_o),
        .refr_ack_i(refr_ack),
        .sref_req_o(sref_req_o), .sref_en_o(sref_en_o), .sref_ack_i(sref_ack),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] b_code(input int i);
        case (i)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b011;
            3: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic int b_ratio(input int i);
        case (i)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int b_idx(input logic [2:0] c);
        case (c)
            3'b000: return 0;
            3'b001: return 1;
            3'b011: return 2;
            3'b010: return 3;
            3'b100: return 4;
            default: return -1;
        endcase
    endfunction

    // Event words: kind in [31:24]; 1 = self-refresh {en}, 2 = refresh {drain, ratio}, 3 = divider data
    task automatic push_sref(input bit en);
        exp_q.push_back({8'd1, 23'd0, en});
    endtask
    task automatic push_refr(input int t, input bit drain);
        exp_q.push_back({8'd2, 19'd0, drain, 4'(b_ratio(t))});
    endtask
    task automatic push_div(input int t);
        exp_ctl[2:0] = b_code(t);
        exp_q.push_back({8'd3, 16'd0, exp_ctl});
    endtask

    task automatic push_leg(input int f, input int t);
        if (f == 1 && t == 0) begin          // R4
            push_sref(1'b0); push_div(t); push_refr(t, 1'b0);
        end else if (f == 0 && t == 1) begin // R3
            push_refr(t, 1'b1); push_div(t); push_sref(1'b1);
        end else if (f < t) begin            // R5
            push_refr(t, 1'b0); push_div(t);
        end else begin                       // R6
            push_div(t); push_refr(t, 1'b1);
        end
    endtask

    task automatic take(input logic [31:0] ev);
        chk((cyc - last_div) >= LOCK, "R8 lock gap", longint'(cyc - last_div), LOCK);
        n_checks++;
        if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R3-order unexpected request actual=%0h expected=none", ev);
        end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            if (e != ev) begin
                n_err++;
                $display("FAIL R3 R4 R5 R6 R7 R2 step actual=%0h expected=%0h", ev, e);
            end
        end
    endtask

    // Monitor and responder: one acknowledge cycle per request.
    always @(negedge clk) begin
        if (rst) begin
            div_ack = 0; refr_ack = 0; sref_ack = 0;
        end else if (div_ack || refr_ack || sref_ack) begin
            div_ack = 0; refr_ack = 0; sref_ack = 0;
        end else begin
            if ((int'(div_wr_req_o) + int'(refr_req_o) + int'(sref_req_o)) > 1)
                chk(1'b0, "R12 one request", {div_wr_req_o, refr_req_o, sref_req_o}, 0);
            if (div_wr_req_o) begin
                take({8'd3, 16'd0, div_wr_data_o});
                env_ctrl = div_wr_data_o;
                last_div = cyc;
                div_ack  = 1;
            end else if (refr_req_o) begin
                take({8'd2, 19'd0, refr_drain_o, refr_ratio_o});
                refr_ack = 1;
            end else if (sref_req_o) begin
                take({8'd1, 23'd0, sref_en_o});
                sref_ack = 1;
            end
        end
    end

    task automatic move(input logic [2:0] tgt, input bit exp_err, input bit poke, input string tag);
        int  o, k;
        bit  legal;
        logic [W-1:0] final_ctl;
        o       = b_idx(env_ctrl[2:0]);
        legal   = (o >= 0) && (tgt < 3'd5);
        exp_ctl = env_ctrl;
        if (legal && o != int'(tgt)) begin
            if ((o == 0 && tgt > 1) || (o > 1 && tgt == 0)) begin // R7
                push_leg(o, 1);
                push_leg(1, int'(tgt));
            end else begin
                push_leg(o, int'(tgt));
            end
        end
        final_ctl = legal ? {env_ctrl[W-1:3], b_code(int'(tgt))} : env_ctrl;
        @(negedge clk);
        start_i = 1'b1; target_idx_i = tgt;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, {"R11 busy after start ", tag}, busy_o, 1);
        k = 0;
        while (!done_o && k < 2000) begin
            @(negedge clk);
            if (poke && k == 3) begin
                start_i = 1'b1; target_idx_i = 3'd4;   // R11: must be ignored
            end else begin
                start_i = 1'b0;
            end
            k++;
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, {"R11 done reached ", tag}, done_o, 1);
        if (!legal)
            chk(k == 0, {"R10 immediate done ", tag}, k, 0);
        else if (o == int'(tgt))
            chk(k == 0, {"R9 immediate done ", tag}, k, 0);
        chk(exp_q.size() == 0, {"R3 R7 all steps issued ", tag}, exp_q.size(), 0);
        exp_q.delete();
        chk(err_o == exp_err, {"R10 error flag ", tag}, err_o, exp_err);
        chk(env_ctrl == final_ctl, {"R1 R2 final control ", tag}, env_ctrl, final_ctl);
        @(negedge clk);
        chk(!busy_o && !done_o, {"R11 idle after done ", tag}, {busy_o, done_o}, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && !err_o, "R10 R11 reset state", {busy_o, done_o, err_o}, 0);
        chk(!div_wr_req_o && !refr_req_o && !sref_req_o, "R12 no request at reset",
            {div_wr_req_o, refr_req_o, sref_req_o}, 0);
    endtask

    initial begin
        env_ctrl = 8'hA8;
        do_reset();
        move(3'd1, 1'b0, 1'b0, "1to2");     // R3
        move(3'd0, 1'b0, 1'b0, "2to1");     // R4
        move(3'd4, 1'b0, 1'b0, "1to8");     // R7
        move(3'd2, 1'b0, 1'b0, "8to4");     // R6
        move(3'd3, 1'b0, 1'b0, "4to6");     // R5
        move(3'd1, 1'b0, 1'b0, "6to2");     // R6
        move(3'd2, 1'b0, 1'b0, "2to4");     // R5
        move(3'd0, 1'b0, 1'b0, "4to1");     // R7
        move(3'd0, 1'b0, 1'b0, "equal");    // R9
        move(3'd1, 1'b0, 1'b1, "poke");     // R11
        move(3'd5, 1'b1, 1'b0, "bad_idx");  // R10
        move(3'd0, 1'b1, 1'b0, "after_err");// R10 sticky
        env_ctrl = 8'h55;
        do_reset();
        move(3'd1, 1'b1, 1'b0, "bad_code"); // R10
        env_ctrl = 8'h52;
        move(3'd1, 1'b1, 1'b0, "hi_bits");  // R2 R6
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule